// File: doc/BRIEF.md
# Sprite table RAM mapper

This block sits between a host CPU's byte bus and an 8 KB save RAM and is modelled here together with that RAM. Nearly every host address reaches the RAM unchanged. The exception is one eight-byte slot near the top of the space, which acts as an indexed window onto a sprite attribute table held in the RAM. Through that slot the CPU picks a table entry by index and then reads or writes the entry's four bytes. It can also drop a 2-bit high attribute into a byte shared by four neighbouring entries without doing any mask-and-shift work in software.

The table can sit at one of two bases in the upper quarter of the RAM. Control bytes written into the slot set the base, the entry index and the 2-bit field position. Each control byte is also stored in the RAM. After reset the block fills the RAM with 0xFF, one byte per clock. It then reloads its control registers by reading those stored bytes back. It ignores the host until this sequence has finished.

The RAM is synchronous and has a single port. Read data appears one clock after the read strobe. A field insert is a read followed by a write, so it holds the bus for one extra cycle, and `ready` is low during that cycle.

Top module: `sprite_ram_mapper`

## Requirements
- R1: Only the low 13 bits of `host_addr` are decoded; bits 15..13 have no effect on which RAM byte is accessed.
- R2: An address whose 13-bit value is outside 0x1FF0..0x1FF7 reads and writes the RAM byte at that address; read data is on `host_rdata` one clock after the read strobe.
- R3: A write to 0x1FF5 sets the table base from data bit 0 (1 selects 0x1800, 0 selects 0x1C00) and also stores the byte at RAM 0x1FF5.
- R4: A write to 0x1FF6 sets the entry index to data bits 6..0 and the field position to twice data bits 1..0, and stores the byte at RAM 0x1FF6.
- R5: Accesses to 0x1FF0..0x1FF3 read or write RAM at base + 4×index + (address bits 1..0).
- R6: A read of 0x1FF4 returns the full RAM byte at base + 0x200 + (index ÷ 4, rounded down).
- R7: A write to 0x1FF4 replaces only the two bits of that same byte that start at the field position with data bits 1..0, keeping the other six bits. The write occupies two cycles, and `ready` is low in the cycle after the strobe only.
- R8: Reads of 0x1FF5..0x1FF7 return the stored RAM bytes. A write to 0x1FF7 only stores the byte and changes neither base nor index.
- R9: After reset, `busy` stays high for exactly 8195 cycles (8192 fill cycles plus three reload cycles). The RAM then holds 0xFF everywhere, and the window acts as base 0x1800, index 127 and field position 6.
- R10: Host strobes are ignored while `busy` is high or `ready` is low; the read and write strobes are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the fill sequence |
| host_addr | input | 16 | Host byte address; low 13 bits decoded |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| busy | output | 1 | High during the reset fill and register reload |
| ready | output | 1 | High when a host strobe will be accepted |

## Verification
The main function is exercised with three kinds of pattern. The first is a full sweep over every address outside the window with address-derived data. It catches pass-through decode faults and any overlap between direct space and window. The second sweeps every index 0..127 under both bases through the entry bytes and the shared attribute byte. Each result is read back both through the window and directly, which separates wrong base selection, wrong index scaling and wrong byte offset. The third writes attribute data with the upper six bits set and index bits that walk all four field positions. This exposes a field written at the wrong shift, bits leaking outside the field, or neighbouring fields being clobbered.

// File: rtl/smap_pkg.sv
package smap_pkg;

    localparam int ENTRY_BYTES_LOG2 = 2;
    localparam int FIELD_W          = 2;
    localparam int WIN_SLOTS_LOG2   = 3;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_LD_BASE,
        ST_LD_INDEX,
        ST_LD_DONE,
        ST_IDLE,
        ST_MERGE
    } ctl_state_e;

    typedef enum logic [2:0] {
        ACC_DIRECT,
        ACC_ENTRY,
        ACC_ATTR,
        ACC_BASE_SEL,
        ACC_INDEX,
        ACC_SPARE
    } acc_kind_e;

endpackage

// File: rtl/smap_addr_xlate.sv
module smap_addr_xlate
    import smap_pkg::*;
#(
    parameter int RAM_AW = 13,
    parameter int IDX_W  = 7
) (
    input  logic [RAM_AW-1:0] addr_i,
    input  logic              base_hi_i,
    input  logic [IDX_W-1:0]  idx_i,
    output acc_kind_e         kind_o,
    output logic [RAM_AW-1:0] phys_o
);

    localparam logic [RAM_AW-1:0] WIN_ADDR    = {RAM_AW{1'b1}} - RAM_AW'(15);
    localparam logic [RAM_AW-1:0] TBL_BASE_HI = RAM_AW'(3) << (RAM_AW - 2);
    localparam logic [RAM_AW-1:0] TBL_BASE_LO = RAM_AW'(7) << (RAM_AW - 3);
    localparam logic [RAM_AW-1:0] ATTR_OFS    = RAM_AW'(1) << (RAM_AW - 4);
    localparam int                ATTR_SPAN   = 2 ** (IDX_W - ENTRY_BYTES_LOG2);

    logic              in_window;
    logic [RAM_AW-1:0] tbl_base;
    logic [RAM_AW-1:0] entry_addr;
    logic [RAM_AW-1:0] attr_addr;

    always_comb begin
        in_window  = (addr_i[RAM_AW-1:WIN_SLOTS_LOG2] == WIN_ADDR[RAM_AW-1:WIN_SLOTS_LOG2]);
        tbl_base   = base_hi_i ? TBL_BASE_HI : TBL_BASE_LO;
        entry_addr = tbl_base + (RAM_AW'(idx_i) << ENTRY_BYTES_LOG2)
                   + RAM_AW'(addr_i[ENTRY_BYTES_LOG2-1:0]);
        attr_addr  = tbl_base + ATTR_OFS + RAM_AW'(idx_i >> ENTRY_BYTES_LOG2);

        kind_o = ACC_DIRECT;
        phys_o = addr_i;
        if (in_window) begin
            unique case (addr_i[WIN_SLOTS_LOG2-1:0])
                3'd0, 3'd1, 3'd2, 3'd3: begin
                    kind_o = ACC_ENTRY;
                    phys_o = entry_addr;
                end
                3'd4: begin
                    kind_o = ACC_ATTR;
                    phys_o = attr_addr;
                end
                3'd5:    kind_o = ACC_BASE_SEL;
                3'd6:    kind_o = ACC_INDEX;
                default: kind_o = ACC_SPARE;
            endcase
        end
    end

    // R5: an entry byte lies in the first 0x200 bytes above the table base
    always_comb begin
        p_entry_region_r5: assert (kind_o != ACC_ENTRY ||
                                   (phys_o - tbl_base) < ATTR_OFS)
            else $error("entry byte outside table region");
    end

    // R6: the attribute byte lies in the short run just after the entry bytes
    always_comb begin
        p_attr_region_r6: assert (kind_o != ACC_ATTR ||
                                  ((phys_o - tbl_base) >= ATTR_OFS &&
                                   (phys_o - tbl_base) < ATTR_OFS + RAM_AW'(ATTR_SPAN)))
            else $error("attribute byte outside attribute region");
    end

    // R2: addresses outside the window pass through unchanged
    always_comb begin
        p_direct_pass_r2: assert (in_window || (kind_o == ACC_DIRECT && phys_o == addr_i))
            else $error("direct address altered");
    end

endmodule

// File: rtl/smap_ram.sv
module smap_ram #(
    parameter int AW         = 13,
    parameter int DW         = 8,
    parameter int BANKS_LOG2 = 2
) (
    input  logic          clk,
    input  logic          en_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    localparam int NBANKS     = 2 ** BANKS_LOG2;
    localparam int BANK_DEPTH = 2 ** (AW - BANKS_LOG2);

    logic [NBANKS-1:0][DW-1:0] rd_all;
    logic [BANKS_LOG2-1:0]     rd_bank_q;
    logic [BANKS_LOG2-1:0]     rd_bank_d;
    logic [AW-BANKS_LOG2-1:0]  row;
    logic [BANKS_LOG2-1:0]     bank;

    always_comb begin
        row       = addr_i[AW-1:BANKS_LOG2];
        bank      = addr_i[BANKS_LOG2-1:0];
        rd_bank_d = (en_i && !we_i) ? bank : rd_bank_q;
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [DW-1:0] mem [BANK_DEPTH];
        logic [DW-1:0] rd_q;
        logic          hit;

        always_comb hit = en_i && (bank == BANKS_LOG2'(b));

        always_ff @(posedge clk) begin
            if (hit) begin
                if (we_i) mem[row] <= wdata_i;
                else      rd_q     <= mem[row];
            end
        end

        assign rd_all[b] = rd_q;
    end

    always_ff @(posedge clk) rd_bank_q <= rd_bank_d;

    always_comb rdata_o = rd_all[rd_bank_q];

endmodule

// File: rtl/smap_field_merge.sv
module smap_field_merge
    import smap_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SH_W = $clog2(DW)
) (
    input  logic [DW-1:0]      old_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [SH_W-1:0]    shift_i,
    output logic [DW-1:0]      merged_o
);

    logic [DW-1:0] mask;
    logic [DW-1:0] placed;

    always_comb begin
        mask     = DW'({FIELD_W{1'b1}}) << shift_i;
        placed   = DW'(field_i) << shift_i;
        merged_o = (old_i & ~mask) | (placed & mask);
    end

endmodule

// File: rtl/sprite_ram_mapper.sv
module sprite_ram_mapper
    import smap_pkg::*;
#(
    parameter int HOST_AW = 16,
    parameter int RAM_AW  = 13,
    parameter int DW      = 8,
    parameter int IDX_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               busy,
    output logic               ready
);

    localparam int                SH_W       = $clog2(DW);
    localparam logic [RAM_AW-1:0] WIN_ADDR   = {RAM_AW{1'b1}} - RAM_AW'(15);
    localparam logic [RAM_AW-1:0] BASE_REG_A = WIN_ADDR + RAM_AW'(5);
    localparam logic [RAM_AW-1:0] IDX_REG_A  = WIN_ADDR + RAM_AW'(6);
    localparam logic [RAM_AW-1:0] ATTR_REG_A = WIN_ADDR + RAM_AW'(4);

    typedef struct packed {
        ctl_state_e         state;
        logic [RAM_AW-1:0]  fill_cnt;
        logic               base_hi;
        logic [IDX_W-1:0]   idx;
        logic [SH_W-1:0]    shift;
        logic [RAM_AW-1:0]  merge_addr;
        logic [FIELD_W-1:0] merge_field;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:       ST_FILL,
        fill_cnt:    '0,
        base_hi:     1'b0,
        idx:         '0,
        shift:       '0,
        merge_addr:  '0,
        merge_field: '0
    };

    ctl_t ctl_q, ctl_d;

    logic [RAM_AW-1:0] host_a13;
    logic              unused_addr_hi;
    acc_kind_e         xl_kind;
    logic [RAM_AW-1:0] xl_phys;

    logic              ram_en;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [DW-1:0]     ram_wdata;
    logic [DW-1:0]     ram_rdata;
    logic [DW-1:0]     merged;

    assign host_a13       = host_addr[RAM_AW-1:0];
    assign unused_addr_hi = ^host_addr[HOST_AW-1:RAM_AW];

    smap_addr_xlate #(
        .RAM_AW (RAM_AW),
        .IDX_W  (IDX_W)
    ) i_xlate (
        .addr_i    (host_a13),
        .base_hi_i (ctl_q.base_hi),
        .idx_i     (ctl_q.idx),
        .kind_o    (xl_kind),
        .phys_o    (xl_phys)
    );

    smap_field_merge #(
        .DW   (DW),
        .SH_W (SH_W)
    ) i_merge (
        .old_i    (ram_rdata),
        .field_i  (ctl_q.merge_field),
        .shift_i  (ctl_q.shift),
        .merged_o (merged)
    );

    smap_ram #(
        .AW         (RAM_AW),
        .DW         (DW),
        .BANKS_LOG2 (ENTRY_BYTES_LOG2)
    ) i_ram (
        .clk     (clk),
        .en_i    (ram_en),
        .we_i    (ram_we),
        .addr_i  (ram_addr),
        .wdata_i (ram_wdata),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;

        unique case (ctl_q.state)
            ST_FILL: begin
                ram_en         = 1'b1;
                ram_we         = 1'b1;
                ram_addr       = ctl_q.fill_cnt;
                ram_wdata      = '1;
                ctl_d.fill_cnt = ctl_q.fill_cnt + RAM_AW'(1);
                if (ctl_q.fill_cnt == '1) ctl_d.state = ST_LD_BASE;
            end
            ST_LD_BASE: begin
                ram_en      = 1'b1;
                ram_addr    = BASE_REG_A;
                ctl_d.state = ST_LD_INDEX;
            end
            ST_LD_INDEX: begin
                ctl_d.base_hi = ram_rdata[0];
                ram_en        = 1'b1;
                ram_addr      = IDX_REG_A;
                ctl_d.state   = ST_LD_DONE;
            end
            ST_LD_DONE: begin
                ctl_d.idx   = ram_rdata[IDX_W-1:0];
                ctl_d.shift = SH_W'(ram_rdata[FIELD_W-1:0]) * SH_W'(FIELD_W);
                ctl_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (host_wr) begin
                    ram_en    = 1'b1;
                    ram_we    = 1'b1;
                    ram_addr  = xl_phys;
                    ram_wdata = host_wdata;
                    unique case (xl_kind)
                        ACC_ATTR: begin
                            ram_we            = 1'b0;
                            ctl_d.merge_addr  = xl_phys;
                            ctl_d.merge_field = host_wdata[FIELD_W-1:0];
                            ctl_d.state       = ST_MERGE;
                        end
                        ACC_BASE_SEL: ctl_d.base_hi = host_wdata[0];
                        ACC_INDEX: begin
                            ctl_d.idx   = host_wdata[IDX_W-1:0];
                            ctl_d.shift = SH_W'(host_wdata[FIELD_W-1:0]) * SH_W'(FIELD_W);
                        end
                        default: ;
                    endcase
                end else if (host_rd) begin
                    ram_en   = 1'b1;
                    ram_addr = xl_phys;
                end
            end
            ST_MERGE: begin
                ram_en      = 1'b1;
                ram_we      = 1'b1;
                ram_addr    = ctl_q.merge_addr;
                ram_wdata   = merged;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign host_rdata = ram_rdata;
    assign ready      = (ctl_q.state == ST_IDLE);
    assign busy       = (ctl_q.state != ST_IDLE) && (ctl_q.state != ST_MERGE);

    // R9: no access is accepted while the fill or reload runs
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready)
        else $error("ready during fill");

    // R9: once the fill and reload are finished, busy does not return
    p_busy_stays_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy)
        else $error("busy reasserted");

    // R7: an accepted attribute write stalls the bus for the next cycle
    p_attr_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && host_wr && host_a13 == ATTR_REG_A) |=> !ready)
        else $error("attribute write did not stall");

    // R7: the stall lasts exactly one cycle
    p_stall_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !busy) |=> ready)
        else $error("stall longer than one cycle");

    // R7: the merge write keeps every bit outside the selected field
    p_merge_keeps_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_MERGE) |->
        (((ram_wdata ^ ram_rdata) & ~(DW'({FIELD_W{1'b1}}) << ctl_q.shift)) == '0))
        else $error("merge altered bits outside field");

    // R3: a base write takes effect on the next cycle
    p_base_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && host_wr && host_a13 == BASE_REG_A) |=> (ctl_q.base_hi == $past(host_wdata[0])))
        else $error("base select not updated");

    // R10: read and write strobes never coincide
    p_no_dual_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr))
        else $error("read and write strobes together");

endmodule

// File: tb/test_sprite_ram_mapper.sv
module test_sprite_ram_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        busy;
    logic        ready;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    logic [7:0] mem_ref [0:8191];
    int base_ref;
    int idx_ref;
    int shift_ref;

    sprite_ram_mapper i_sprite_ram_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .ready      (ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int got, input int exp, input int where);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s at %04h: got %02h expected %02h", tag, where, got, exp);
        end
    endtask

    function automatic bit in_win(input int a);
        return ((a & 8191) & 'h1ff8) == 'h1ff0;
    endfunction

    function automatic int phys_of(input int a);
        int a13 = a & 8191;
        int tb = (base_ref != 0) ? 'h1800 : 'h1c00;
        if (!in_win(a13)) return a13;
        case (a13 & 7)
            0, 1, 2, 3: return tb + idx_ref * 4 + (a13 & 3);
            4:          return tb + 'h200 + (idx_ref >> 2);
            default:    return a13;
        endcase
    endfunction

    task automatic host_write(input int a, input int d, input bit poke, input string tag);
        int a13 = a & 8191;
        int p = phys_of(a13);
        @(negedge clk);
        host_addr  = 16'(a);
        host_wdata = 8'(d);
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (in_win(a13) && (a13 & 7) == 4) begin
            mem_ref[p] = (mem_ref[p] & ~(8'(3) << shift_ref)) | (8'(d & 3) << shift_ref);
            check({tag, " ready low in merge cycle"}, int'(ready), 0, a13);
            if (poke) begin
                host_addr  = 16'h0040;
                host_wdata = 8'ha5;
                host_wr    = 1'b1;
            end
            @(negedge clk);
            host_wr = 1'b0;
            check({tag, " ready back"}, int'(ready), 1, a13);
        end else begin
            mem_ref[p] = 8'(d);
            if (in_win(a13) && (a13 & 7) == 5) base_ref = d & 1;
            if (in_win(a13) && (a13 & 7) == 6) begin
                idx_ref   = d & 'h7f;
                shift_ref = (d & 3) * 2;
            end
        end
    endtask

    task automatic host_read(input int a, input string tag);
        int p = phys_of(a);
        @(negedge clk);
        host_addr = 16'(a);
        host_rd   = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check(tag, int'(host_rdata), int'(mem_ref[p]), a & 8191);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                mismatched++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        int busy_cycles;
        for (int i = 0; i < 8192; i++) mem_ref[i] = 8'hff;
        base_ref  = 1;
        idx_ref   = 127;
        shift_ref = 6;

        // R9: state while reset is held
        @(negedge clk);
        check("R9 busy in reset", int'(busy), 1, 0);
        check("R9 ready in reset", int'(ready), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: fill length; R10: a write issued during the fill is dropped
        busy_cycles = 0;
        while (busy && busy_cycles < 9000) begin
            busy_cycles++;
            if (busy_cycles == 100) begin
                host_addr  = 16'h0100;
                host_wdata = 8'h12;
                host_wr    = 1'b1;
            end else begin
                host_wr = 1'b0;
            end
            @(negedge clk);
        end
        host_wr = 1'b0;
        check("R9 busy cycle count", busy_cycles, 8195, 0);
        check("R9 ready after fill", int'(ready), 1, 0);
        host_read('h0100, "R10 write during fill ignored");

        // R9: fill value and reloaded window state
        host_read('h0000, "R9 fill low");
        host_read('h1fff, "R9 fill top");
        host_read('h1ff5, "R9 fill base byte");
        host_read('h1ff6, "R9 fill index byte");
        host_write('h1ff1, 'h3c, 1'b0, "R9");
        host_read('h19fd, "R9 reloaded index and base");
        host_write('h1ff4, 'h01, 1'b0, "R9");
        host_read('h1a1f, "R9 reloaded field position");

        // R2: full sweep of direct space
        for (int a = 0; a < 8192; a++)
            if (!in_win(a)) host_write(a, (a * 37 + (a >> 5)) & 255, 1'b0, "R2");
        for (int a = 0; a < 8192; a++)
            if (!in_win(a)) host_read(a, "R2 direct sweep");

        // R1: upper address bits ignored
        host_write('he123, 'h6b, 1'b0, "R1");
        host_read('h0123, "R1 aliased write");
        host_read('h6123, "R1 aliased read");

        // R3, R4, R5: entry bytes for every index under both bases
        for (int b = 0; b < 2; b++) begin
            host_write('h1ff5, 'ha0 | b, 1'b0, "R3");
            host_read('h1ff5, "R3 base byte stored");
            for (int i = 0; i < 128; i++) begin
                host_write('h1ff6, i | 'h80, 1'b0, "R4");
                for (int n = 0; n < 4; n++)
                    host_write('h1ff0 + n, (i * 5 + n * 17 + b * 101) & 255, 1'b0, "R5");
                for (int n = 0; n < 4; n++) begin
                    host_read('h1ff0 + n, "R5 window entry read");
                    host_read(phys_of('h1ff0 + n), "R3 R5 direct entry read");
                end
            end
            host_read('h1ff6, "R4 index byte stored");
        end

        // R6, R7: attribute field insert for every index under both bases
        for (int b = 0; b < 2; b++) begin
            host_write('h1ff5, b, 1'b0, "R3");
            for (int i = 0; i < 128; i++) begin
                host_write('h1ff6, i, 1'b0, "R4");
                host_write('h1ff4, 'hfc | ((i * 3 + b) & 3), 1'b0, "R7");
                host_read('h1ff4, "R6 R7 attribute window read");
                host_read(phys_of('h1ff4), "R7 attribute direct read");
            end
        end

        // R8: spare byte has no side effect
        host_write('h1ff6, 'h2a, 1'b0, "R4");
        host_write('h1ff7, 'h5a, 1'b0, "R8");
        host_read('h1ff7, "R8 spare byte stored");
        host_read('h1ff0, "R8 mapping unchanged");
        host_read('h1ff4, "R8 attribute mapping unchanged");
        host_read('h1ff5, "R8 base byte readback");

        // R10: a write during the merge stall is dropped
        host_write('h1ff4, 'h02, 1'b1, "R10");
        host_read('h0040, "R10 write during stall ignored");
        host_read('h1ff4, "R10 merge result");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule